// File: doc/BRIEF.md
# Move-to-Tail Thread Fetch Selector

This block decides which hardware thread of a multithreaded core gets a fetch slot. It holds an ordered list of thread numbers. For each requested slot it walks that list from the head and grants the first thread whose fetch state allows fetching. The granted thread then leaves its place and goes to the tail of the list. Every thread it passed over keeps its place relative to the others. This differs from a rotating-pointer arbiter, where the skipped threads move along with the pointer.

A core with several fetch slots per cycle raises several strobes in the same cycle. The slots are resolved in a fixed order, and each one sees the list as the previous slot left it. A thread-count input limits the set of threads that can be granted. A count of one switches to single-thread mode, in which no list rotation happens. Grants are registered, so they appear one clock after the strobe.

Top module: `rr_thread_picker`

## Requirements
- R1: While reset is asserted and after it, every grant-valid output is 0. The list holds thread numbers in ascending order, so with all threads eligible the first grants after reset are 0, 1, 2, 3 in turn.
- R2: Each thread's state is a 3-bit code: 0 running, 1 idle, 2 line fill complete, 3 blocked, 4 squashing, 5 awaiting response, 6 awaiting retry, 7 quiesced. Only codes 0, 1 and 2 make a thread eligible.
- R3: A requesting slot grants the eligible thread that stands nearest the head of the list.
- R4: The granted thread moves to the tail of the list. All other entries keep their relative order.
- R5: When no thread is eligible, every requesting slot of that cycle reports no grant, and the list is left unchanged.
- R6: A thread whose number is not less than `cfg_threads` is never granted. A count of 0 grants nothing.
- R7: With `cfg_threads` equal to 1, a requesting slot grants thread 0 when it is eligible and reports no grant otherwise. The list order is not changed.
- R8: Slots requested in the same cycle are resolved from slot 0 upward. Each slot sees the list as rotated by the lower slots, and all slots use the same eligibility. If thread 3 is the only eligible thread, both slots grant thread 3.
- R9: A slot whose strobe is low grants nothing and leaves the list untouched. Slots above it are still served.
- R10: A grant for a strobe sampled at one rising edge shows on `gnt_vld`/`gnt_id` right after that edge. It lasts for exactly that cycle unless it is requested again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_threads | input | CNT_W (3) | Number of configured threads |
| thr_state | input | 3*N_THREADS (12) | Per-thread fetch state codes, thread i at bits [3i+2:3i] |
| sel_req | input | N_SLOTS (2) | Per-slot select strobes |
| gnt_vld | output | N_SLOTS (2) | Per-slot grant valid |
| gnt_id | output | N_SLOTS*IDW (4) | Per-slot granted thread, slot k at bits [IDW*k+IDW-1:IDW*k] |

## Verification
Each grant is due one clock after the strobe, because it passes through a single output register. The list rotation applies at that same edge, and it becomes visible only through the order of later grants. The bench changes inputs on the falling edge. At the next falling edge it compares the outputs with a model run on the previous stimulus, so every comparison lands exactly one register stage behind its stimulus. Order preservation and the unchanged list after an empty cycle are checked through the grant sequences of the cycles that follow.

// File: rtl/rrsel_pkg.sv
package rrsel_pkg;

   localparam int STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      TS_RUN        = 3'd0,
      TS_IDLE       = 3'd1,
      TS_FILLED     = 3'd2,
      TS_BLOCKED    = 3'd3,
      TS_SQUASH     = 3'd4,
      TS_WAIT_RSP   = 3'd5,
      TS_WAIT_RETRY = 3'd6,
      TS_QUIESCE    = 3'd7
   } thr_state_e;

   // R2: only these three states may take a fetch slot
   function automatic logic can_fetch(input logic [STATE_W-1:0] s);
      case (thr_state_e'(s))
         TS_RUN, TS_IDLE, TS_FILLED: can_fetch = 1'b1;
         default:                    can_fetch = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/rrsel_elig.sv
module rrsel_elig
   import rrsel_pkg::*;
#(
   parameter int N_THREADS = 4,
   parameter int CNT_W     = 3
) (
   input  logic [N_THREADS*STATE_W-1:0] thr_state,
   input  logic [CNT_W-1:0]             cfg_threads,
   output logic [N_THREADS-1:0]         elig,
   output logic                         single
);

   assign single = (cfg_threads <= CNT_W'(1));

   for (genvar i = 0; i < N_THREADS; i++) begin : g_thr
      assign elig[i] = can_fetch(thr_state[i*STATE_W +: STATE_W]) &&
                       (CNT_W'(i) < cfg_threads);
   end

endmodule

// File: rtl/rrsel_slot.sv
module rrsel_slot #(
   parameter int N_THREADS = 4,
   parameter int IDW       = 2
) (
   input  logic                              en,
   input  logic                              single,
   input  logic [N_THREADS-1:0]              elig,
   input  logic [N_THREADS-1:0][IDW-1:0]     list_i,
   output logic                              found,
   output logic [IDW-1:0]                    gnt_id,
   output logic [N_THREADS-1:0][IDW-1:0]     list_o
);

   logic           hit;
   logic [IDW-1:0] pos;

   always_comb begin
      hit    = 1'b0;
      pos    = '0;
      gnt_id = '0;
      if (single) begin
         hit = elig[0];
      end else begin
         for (int p = 0; p < N_THREADS; p++) begin
            if (!hit && elig[list_i[p]]) begin
               hit    = 1'b1;
               pos    = IDW'(p);
               gnt_id = list_i[p];
            end
         end
      end
      found = en && hit;
   end

   // removal at pos, close the gap, append granted id at the tail
   always_comb begin
      list_o = list_i;
      if (found && !single) begin
         for (int i = 0; i < N_THREADS-1; i++) begin
            if (IDW'(i) >= pos) list_o[i] = list_i[i+1];
         end
         list_o[N_THREADS-1] = gnt_id;
      end
   end

endmodule

// File: rtl/rr_thread_picker.sv
module rr_thread_picker
   import rrsel_pkg::*;
#(
   parameter  int N_THREADS = 4,
   parameter  int N_SLOTS   = 2,
   localparam int IDW       = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
   localparam int CNT_W     = $clog2(N_THREADS + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [CNT_W-1:0]             cfg_threads,
   input  logic [N_THREADS*STATE_W-1:0] thr_state,
   input  logic [N_SLOTS-1:0]           sel_req,
   output logic [N_SLOTS-1:0]           gnt_vld,
   output logic [N_SLOTS*IDW-1:0]       gnt_id
);

   if (N_THREADS < 2) begin : g_bad_threads
      $error("rr_thread_picker: N_THREADS must be at least 2");
   end
   if (N_SLOTS < 1) begin : g_bad_slots
      $error("rr_thread_picker: N_SLOTS must be at least 1");
   end

   logic [N_THREADS-1:0]           elig;
   logic                           single;
   logic [N_THREADS-1:0][IDW-1:0]  list_q;
   logic [N_THREADS-1:0][IDW-1:0]  chain [N_SLOTS+1];
   logic [N_SLOTS-1:0]             hit;
   logic [N_SLOTS*IDW-1:0]         sid;

   rrsel_elig #(.N_THREADS(N_THREADS), .CNT_W(CNT_W)) i_elig (
      .thr_state   (thr_state),
      .cfg_threads (cfg_threads),
      .elig        (elig),
      .single      (single)
   );

   assign chain[0] = list_q;

   for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
      rrsel_slot #(.N_THREADS(N_THREADS), .IDW(IDW)) i_slot (
         .en     (sel_req[k]),
         .single (single),
         .elig   (elig),
         .list_i (chain[k]),
         .found  (hit[k]),
         .gnt_id (sid[k*IDW +: IDW]),
         .list_o (chain[k+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_THREADS; i++) list_q[i] <= IDW'(i);
         gnt_vld <= '0;
         gnt_id  <= '0;
      end else begin
         list_q  <= chain[N_SLOTS];
         gnt_vld <= hit;
         gnt_id  <= sid;
      end
   end

endmodule

// File: rtl/rr_thread_picker_chk.sv
module rr_thread_picker_chk
   import rrsel_pkg::*;
#(
   parameter  int N_THREADS = 4,
   parameter  int N_SLOTS   = 2,
   localparam int IDW       = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
   localparam int CNT_W     = $clog2(N_THREADS + 1)
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [CNT_W-1:0]             cfg_threads,
   input logic [N_THREADS*STATE_W-1:0] thr_state,
   input logic [N_SLOTS-1:0]           sel_req,
   input logic [N_SLOTS-1:0]           gnt_vld,
   input logic [N_SLOTS*IDW-1:0]       gnt_id,
   input logic [N_THREADS-1:0][IDW-1:0] list_q
);

   logic [N_THREADS-1:0] present;
   logic [N_THREADS-1:0] ok_now, ok_prev;
   logic                 single_prev;

   always_comb begin
      present = '0;
      for (int i = 0; i < N_THREADS; i++) present[list_q[i]] = 1'b1;
      for (int i = 0; i < N_THREADS; i++)
         ok_now[i] = can_fetch(thr_state[i*STATE_W +: STATE_W]) &&
                     (CNT_W'(i) < cfg_threads);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok_prev     <= '0;
         single_prev <= 1'b0;
      end else begin
         ok_prev     <= ok_now;
         single_prev <= (cfg_threads <= CNT_W'(1));
      end
   end

   // R4: the list always holds every thread number exactly once
   a_r4_list_perm: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(present) == N_THREADS);

   // R5: without any grant the list must not move
   a_r5_hold_list: assert property (@(posedge clk) disable iff (!rst_n)
      !(|gnt_vld) |-> $stable(list_q));

   for (genvar k = 0; k < N_SLOTS; k++) begin : g_k
      // R9 / R10: a grant only follows a strobe one edge earlier
      a_r9_no_req_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(sel_req[k]) |-> !gnt_vld[k]);
      // R2 / R6: granted thread was eligible when the strobe was sampled
      a_r2_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
         gnt_vld[k] |-> ok_prev[gnt_id[k*IDW +: IDW]]);
      // R7: single-thread mode only ever grants thread 0
      a_r7_single_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt_vld[k] && single_prev) |-> (gnt_id[k*IDW +: IDW] == '0));
   end

endmodule

bind rr_thread_picker rr_thread_picker_chk #(
   .N_THREADS (N_THREADS),
   .N_SLOTS   (N_SLOTS)
) i_chk (.*);

// File: tb/test_rr_thread_picker.sv
`timescale 1ns/1ps
module test_rr_thread_picker;

   localparam int NT = 4;
   localparam int NS = 2;
   localparam int IW = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2:0]       cfg_threads = 3'd4;
   logic [NT*3-1:0]  thr_state = '0;
   logic [NS-1:0]    sel_req = '0;
   logic [NS-1:0]    gnt_vld;
   logic [NS*IW-1:0] gnt_id;

   int    n_chk = 0, n_bad = 0;
   int    mlist [NT];
   bit    ev [NS];
   int    eid [NS];
   bit    pend = 0;
   bit    done = 0;
   string ptag = "";

   always #4 clk = ~clk;  // 125 MHz

   rr_thread_picker #(.N_THREADS(NT), .N_SLOTS(NS)) i_rr_thread_picker (
      .clk(clk), .rst_n(rst_n), .cfg_threads(cfg_threads),
      .thr_state(thr_state), .sel_req(sel_req),
      .gnt_vld(gnt_vld), .gnt_id(gnt_id));

   // R2 / R6 eligibility from the spec encoding
   function automatic bit elig_of(int t);
      int s = int'(thr_state[t*3 +: 3]);
      return (t < int'(cfg_threads)) && (s <= 2);
   endfunction

   task automatic model();
      for (int k = 0; k < NS; k++) begin
         ev[k] = 0; eid[k] = 0;
         if (sel_req[k]) begin
            if (cfg_threads <= 3'd1) begin         // R7
               if (elig_of(0)) ev[k] = 1;
            end else begin
               for (int p = 0; p < NT; p++) begin
                  if (!ev[k] && elig_of(mlist[p])) begin
                     ev[k] = 1; eid[k] = mlist[p];
                     for (int i = p; i < NT-1; i++) mlist[i] = mlist[i+1];
                     mlist[NT-1] = eid[k];          // R4
                  end
               end
            end
         end
      end
   endtask

   task automatic compare();
      for (int k = 0; k < NS; k++) begin
         n_chk++;
         if (gnt_vld[k] !== ev[k]) begin
            n_bad++;
            $display("FAIL %s slot %0d valid act=%0b exp=%0b", ptag, k, gnt_vld[k], ev[k]);
         end else if (ev[k]) begin
            n_chk++;
            if (int'(gnt_id[k*IW +: IW]) != eid[k]) begin
               n_bad++;
               $display("FAIL %s slot %0d id act=%0d exp=%0d", ptag, k, gnt_id[k*IW +: IW], eid[k]);
            end
         end
      end
   endtask

   task automatic cyc(input logic [NT*3-1:0] st, input logic [2:0] cf,
                      input logic [NS-1:0] rq, input string tag);
      @(negedge clk);
      if (pend) compare();
      thr_state = st; cfg_threads = cf; sel_req = rq;
      model();
      pend = 1; ptag = tag;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8*200000);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < NT; i++) mlist[i] = i;
      sel_req = 2'b11;
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset even with strobes raised
      for (int k = 0; k < NS; k++) begin
         n_chk++;
         if (gnt_vld[k] !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset slot %0d act=%0b exp=0", k, gnt_vld[k]);
         end
      end
      sel_req = '0;
      @(negedge clk); rst_n = 1'b1;

      // R1 / R3: ascending order after reset
      repeat (4) cyc(12'h000, 3'd4, 2'b01, "R1");
      // R2: codes 3 and 7 block, 1 and 2 fetch: t0=3 t1=1 t2=2 t3=7
      repeat (3) cyc({3'd7, 3'd2, 3'd1, 3'd3}, 3'd4, 2'b01, "R2");
      cyc({3'd6, 3'd5, 3'd4, 3'd0}, 3'd4, 2'b01, "R2");
      // R4: thread 0 held off, then all open, order of skipped kept
      repeat (2) cyc({3'd0, 3'd0, 3'd0, 3'd3}, 3'd4, 2'b01, "R4");
      repeat (4) cyc(12'h000, 3'd4, 2'b01, "R4");
      // R5: nobody eligible, then list proven unchanged
      cyc({3'd3, 3'd4, 3'd5, 3'd6}, 3'd4, 2'b11, "R5");
      repeat (2) cyc(12'h000, 3'd4, 2'b11, "R5");
      // R6: thread count limits
      repeat (3) cyc(12'h000, 3'd2, 2'b11, "R6");
      cyc(12'h000, 3'd0, 2'b11, "R6");
      // R7: single-thread mode
      cyc(12'h000, 3'd1, 2'b11, "R7");
      cyc({3'd0, 3'd0, 3'd0, 3'd3}, 3'd1, 2'b11, "R7");
      repeat (2) cyc(12'h000, 3'd4, 2'b11, "R7");
      // R8: one eligible thread takes both slots
      cyc({3'd0, 3'd3, 3'd3, 3'd3}, 3'd4, 2'b11, "R8");
      repeat (2) cyc(12'h000, 3'd4, 2'b11, "R8");
      // R9: lower slot idle, upper slot served
      repeat (2) cyc(12'h000, 3'd4, 2'b10, "R9");
      // R10: single-cycle pulse
      cyc(12'h000, 3'd4, 2'b01, "R10");
      cyc(12'h000, 3'd4, 2'b00, "R10");
      cyc(12'h000, 3'd4, 2'b00, "R10");

      // random mix checked against the model (R3, R4, R8)
      for (int n = 0; n < 3000; n++) begin
         logic [NT*3-1:0] st;
         for (int t = 0; t < NT; t++)
            st[t*3 +: 3] = ($urandom % 2 == 0) ? 3'd0 : 3'($urandom % 8);
         cyc(st, 3'($urandom % 5), 2'($urandom % 4), "R3");
      end
      cyc(12'h000, 3'd4, 2'b00, "R10");
      @(negedge clk);
      summary();
   end

endmodule